// File: doc/BRIEF.md
# Accumulator ALU with Condition Flags and Branch Test

This block is the arithmetic and logic stage of a small accumulator machine. Each cycle it takes two operands, the current carry flag and a 3-bit operation select. It produces a result and five condition flags: half-carry H, negative N, zero Z, overflow V and carry C. The operations are add, add with carry, subtract, increment, decrement, rotate left through carry, rotate right through carry and pass-through. One shared adder serves add, add with carry, subtract, increment and decrement. The rotates use a separate path.

The result and the flags are captured in an output register, so the block behaves like the accumulator and condition register stage of a datapath. A branch-condition evaluator reads the captured flags and a 3-bit condition select. It drives a combinational "branch taken" output, which lets the sequencer resolve a conditional branch in the cycle after the flags settle.

The operand width is a parameter (default 8). H is the carry across the half-word boundary, which is bit 3 into bit 4 at the default width. The output register can be left out through a parameter for use in a purely combinational stage.

Top module: `acc_alu_cc`

## Requirements
- R1: Op code 0 (add) gives `res = a + b` modulo 256. C is the carry out of bit 7. H is the carry out of bit 3 into bit 4. V is set when a and b have equal sign bits and the result's sign differs from them. Example: 0x3D+0xE2 gives 0x1F with C=1, H=0, V=0. Example: 0xBD+0xA3 gives 0x60 with C=1, H=1, V=1.
- R2: Op code 1 (add with carry) behaves as R1 but also adds the carry input. H, C and V account for that extra one.
- R3: Op code 2 (subtract) gives `res = a - b` modulo 256. C is set when a borrow occurs, meaning b is larger than a when both are read as unsigned. V is set when a and b differ in sign and the result's sign differs from a. H is 0.
- R4: Op code 3 (increment) gives a+1 and op code 4 (decrement) gives a-1. Both ignore b and leave C equal to the carry input. V is set only for 0x7F on increment and only for 0x80 on decrement. H is 0.
- R5: Op code 5 (rotate left through carry) gives `{a[6:0], c_in}` with C = a[7]. Op code 6 (rotate right through carry) gives `{c_in, a[7:1]}` with C = a[0]. For both, V = N xor C of the new values and H is 0.
- R6: Op code 7 (pass) gives res = a with V=0, H=0 and C equal to the carry input.
- R7: For every operation, N equals bit 7 of the result and Z is set exactly when the result is zero.
- R8: Result and flags appear on the outputs one clock after the inputs are applied. While reset is low, the result is 0, Z is 1 and H, N, V and C are 0.
- R9: The branch output is a combinational function of the captured flags and the condition select. The encoding is 0: Z=1, 1: Z=0, 2: N=1, 3: N=0, 4: C=1, 5: C=0, 6: V=1, 7: V=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low synchronous reset of the output register |
| op_i | input | 3 | Operation select (R1 to R6 encodings) |
| a_i | input | 8 | First operand, also the only operand for unary operations |
| b_i | input | 8 | Second operand |
| c_i | input | 1 | Carry input (current C flag) |
| cond_i | input | 3 | Branch condition select (R9 encoding) |
| res_o | output | 8 | Registered result |
| h_o | output | 1 | Half-carry flag |
| n_o | output | 1 | Negative flag |
| z_o | output | 1 | Zero flag |
| v_o | output | 1 | Overflow flag |
| c_o | output | 1 | Carry flag |
| br_o | output | 1 | Branch taken |

## Verification
The assertions check the following on every cycle:
- N and Z agree with the registered result.
- H stays clear outside the two add operations.
- Increment and decrement carry the input carry through unchanged.
- Rotate left moves bit 7 into C and the old carry into bit 0.
- Pass copies the operand.
- The equal-condition branch follows Z.

The arithmetic values can only be shown by the bench's scenarios. These are the half-carry and overflow corner cases, borrow on subtract, and wraparound at 0x7F, 0x80, 0x00 and 0xFF. The scenarios also cover all eight branch encodings for each result and the reset values.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

   localparam int OP_W   = 3;
   localparam int COND_W = 3;

   typedef enum logic [OP_W-1:0] {
      OP_ADD  = 3'd0,
      OP_ADC  = 3'd1,
      OP_SUB  = 3'd2,
      OP_INC  = 3'd3,
      OP_DEC  = 3'd4,
      OP_ROL  = 3'd5,
      OP_ROR  = 3'd6,
      OP_PASS = 3'd7
   } alu_op_e;

   typedef enum logic [COND_W-1:0] {
      CC_ZS = 3'd0,
      CC_ZC = 3'd1,
      CC_NS = 3'd2,
      CC_NC = 3'd3,
      CC_CS = 3'd4,
      CC_CC = 3'd5,
      CC_VS = 3'd6,
      CC_VC = 3'd7
   } br_cond_e;

   typedef struct packed {
      logic h;
      logic n;
      logic z;
      logic v;
      logic c;
   } ccr_t;

endpackage

// File: rtl/alu_adder.sv
module alu_adder #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] x_i,
   input  logic [WIDTH-1:0] y_i,
   input  logic             ci_i,
   output logic [WIDTH-1:0] sum_o,
   output logic             co_o,
   output logic             hc_o,
   output logic             ov_o
);
   localparam int NIB = WIDTH / 2;
   localparam int UPW = WIDTH - NIB;

   logic [NIB:0] lo_sum;
   logic [UPW:0] hi_sum;

   // lower half first: its carry out is the half-carry
   assign lo_sum = {1'b0, x_i[NIB-1:0]} + {1'b0, y_i[NIB-1:0]}
                 + {{NIB{1'b0}}, ci_i};
   assign hi_sum = {1'b0, x_i[WIDTH-1:NIB]} + {1'b0, y_i[WIDTH-1:NIB]}
                 + {{UPW{1'b0}}, lo_sum[NIB]};

   assign sum_o = {hi_sum[UPW-1:0], lo_sum[NIB-1:0]};
   assign co_o  = hi_sum[UPW];
   assign hc_o  = lo_sum[NIB];
   // signed overflow: same-sign addends, differently signed sum
   assign ov_o  = (x_i[WIDTH-1] == y_i[WIDTH-1]) &&
                  (sum_o[WIDTH-1] != x_i[WIDTH-1]);

endmodule

// File: rtl/alu_rotator.sv
module alu_rotator #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] d_i,
   input  logic             ci_i,
   output logic [WIDTH-1:0] rol_o,
   output logic             rol_co_o,
   output logic [WIDTH-1:0] ror_o,
   output logic             ror_co_o
);
   // carry takes part in the rotation as an extra bit
   assign rol_o    = {d_i[WIDTH-2:0], ci_i};
   assign rol_co_o = d_i[WIDTH-1];
   assign ror_o    = {ci_i, d_i[WIDTH-1:1]};
   assign ror_co_o = d_i[0];

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
   import alu8_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic [OP_W-1:0]  op_i,
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             c_i,
   output logic [WIDTH-1:0] res_o,
   output ccr_t             ccr_o
);
   alu_op_e          op;
   logic [WIDTH-1:0] add_y;
   logic             add_ci;
   logic [WIDTH-1:0] add_sum;
   logic             add_co, add_hc, add_ov;
   logic [WIDTH-1:0] rol_r, ror_r;
   logic             rol_c, ror_c;
   logic [WIDTH-1:0] r;
   logic             h, v, c;

   assign op = alu_op_e'(op_i);

   // second adder input and carry-in per operation
   always_comb begin
      add_y  = b_i;
      add_ci = 1'b0;
      case (op)
         OP_ADC:  add_ci = c_i;
         OP_SUB:  begin add_y = ~b_i; add_ci = 1'b1; end
         OP_INC:  begin add_y = '0;   add_ci = 1'b1; end
         OP_DEC:  begin add_y = '1;   add_ci = 1'b0; end
         default: ;
      endcase
   end

   alu_adder #(.WIDTH(WIDTH)) u_add (
      .x_i  (a_i),
      .y_i  (add_y),
      .ci_i (add_ci),
      .sum_o(add_sum),
      .co_o (add_co),
      .hc_o (add_hc),
      .ov_o (add_ov)
   );

   alu_rotator #(.WIDTH(WIDTH)) u_rot (
      .d_i     (a_i),
      .ci_i    (c_i),
      .rol_o   (rol_r),
      .rol_co_o(rol_c),
      .ror_o   (ror_r),
      .ror_co_o(ror_c)
   );

   always_comb begin
      r = a_i;
      h = 1'b0;
      v = 1'b0;
      c = c_i;
      case (op)
         OP_ADD, OP_ADC: begin
            r = add_sum; h = add_hc; v = add_ov; c = add_co;
         end
         OP_SUB: begin
            r = add_sum; v = add_ov; c = ~add_co;   // carry means borrow
         end
         OP_INC, OP_DEC: begin
            r = add_sum; v = add_ov;               // carry left alone
         end
         OP_ROL: begin
            r = rol_r; c = rol_c; v = rol_r[WIDTH-1] ^ rol_c;
         end
         OP_ROR: begin
            r = ror_r; c = ror_c; v = ror_r[WIDTH-1] ^ ror_c;
         end
         default: ;                                // pass
      endcase
   end

   assign res_o   = r;
   assign ccr_o.h = h;
   assign ccr_o.n = r[WIDTH-1];
   assign ccr_o.z = (r == '0);
   assign ccr_o.v = v;
   assign ccr_o.c = c;

endmodule

// File: rtl/alu_cond_eval.sv
module alu_cond_eval
   import alu8_pkg::*;
(
   input  ccr_t              ccr_i,
   input  logic [COND_W-1:0] cond_i,
   output logic              take_o
);
   always_comb begin
      case (br_cond_e'(cond_i))
         CC_ZS:   take_o =  ccr_i.z;
         CC_ZC:   take_o = ~ccr_i.z;
         CC_NS:   take_o =  ccr_i.n;
         CC_NC:   take_o = ~ccr_i.n;
         CC_CS:   take_o =  ccr_i.c;
         CC_CC:   take_o = ~ccr_i.c;
         CC_VS:   take_o =  ccr_i.v;
         default: take_o = ~ccr_i.v;
      endcase
   end

endmodule

// File: rtl/acc_alu_cc.sv
module acc_alu_cc
   import alu8_pkg::*;
#(
   parameter int WIDTH   = 8,
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [OP_W-1:0]   op_i,
   input  logic [WIDTH-1:0]  a_i,
   input  logic [WIDTH-1:0]  b_i,
   input  logic              c_i,
   input  logic [COND_W-1:0] cond_i,
   output logic [WIDTH-1:0]  res_o,
   output logic              h_o,
   output logic              n_o,
   output logic              z_o,
   output logic              v_o,
   output logic              c_o,
   output logic              br_o
);
   if (WIDTH < 4 || (WIDTH % 2) != 0) begin : g_bad_width
      $error("acc_alu_cc: WIDTH must be even and at least 4");
   end

   logic [WIDTH-1:0] res_d, res_q;
   ccr_t             ccr_d, ccr_q;

   alu_datapath #(.WIDTH(WIDTH)) u_dp (
      .op_i (op_i),
      .a_i  (a_i),
      .b_i  (b_i),
      .c_i  (c_i),
      .res_o(res_d),
      .ccr_o(ccr_d)
   );

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            res_q <= '0;
            ccr_q <= '{h: 1'b0, n: 1'b0, z: 1'b1, v: 1'b0, c: 1'b0};
         end else begin
            res_q <= res_d;
            ccr_q <= ccr_d;
         end
      end

      assert_n_tracks_msb_R7: assert property (@(posedge clk) disable iff (!rst_n)
         n_o == res_o[WIDTH-1]);
      assert_z_tracks_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
         z_o == (res_o == '0));
      assert_h_only_on_add_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (op_i != OP_ADD && op_i != OP_ADC) |=> !h_o);
      assert_incdec_keeps_c_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (op_i == OP_INC || op_i == OP_DEC) |=> (c_o == $past(c_i)));
      assert_rol_through_c_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (op_i == OP_ROL) |=> (c_o == $past(a_i[WIDTH-1]) && res_o[0] == $past(c_i)));
      assert_pass_copy_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (op_i == OP_PASS) |=> (res_o == $past(a_i) && !v_o));
      assert_branch_eq_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (cond_i == CC_ZS) |-> (br_o == z_o));
   end else begin : g_comb
      assign res_q = res_d;
      assign ccr_q = ccr_d;
   end

   alu_cond_eval u_br (
      .ccr_i (ccr_q),
      .cond_i(cond_i),
      .take_o(br_o)
   );

   assign res_o = res_q;
   assign h_o   = ccr_q.h;
   assign n_o   = ccr_q.n;
   assign z_o   = ccr_q.z;
   assign v_o   = ccr_q.v;
   assign c_o   = ccr_q.c;

endmodule

// File: tb/sim_acc_alu_cc.sv
`timescale 1ns/10ps
module sim_acc_alu_cc;

   typedef struct {
      logic [7:0] res;
      logic [4:0] hnzvc;
      string      req;
   } item_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] op_i = 3'd0;
   logic [7:0] a_i = 8'h00, b_i = 8'h00;
   logic       c_i = 1'b0;
   logic [2:0] cond_i = 3'd0;
   logic [7:0] res_o;
   logic       h_o, n_o, z_o, v_o, c_o, br_o;

   int    checks = 0;
   int    errors = 0;
   bit    done = 0;
   item_t q[$];

   always #4 clk = ~clk;

   acc_alu_cc u0 (
      .clk(clk), .rst_n(rst_n), .op_i(op_i), .a_i(a_i), .b_i(b_i), .c_i(c_i),
      .cond_i(cond_i), .res_o(res_o), .h_o(h_o), .n_o(n_o), .z_o(z_o),
      .v_o(v_o), .c_o(c_o), .br_o(br_o)
   );

   // reference model written from the requirements
   function automatic item_t model(input logic [2:0] op, input logic [7:0] a,
                                   input logic [7:0] b, input logic c, input string req);
      item_t it;
      int ia = int'(a), ib = int'(b), ic = int'(c), s = 0;
      logic [7:0] r;
      logic h = 0, v = 0, cf = c;
      case (op)
         3'd0: begin s = ia + ib; r = s[7:0]; cf = s > 255;
                  h = (ia % 16 + ib % 16) > 15;
                  v = (a[7] == b[7]) && (r[7] != a[7]); end
         3'd1: begin s = ia + ib + ic; r = s[7:0]; cf = s > 255;
                  h = (ia % 16 + ib % 16 + ic) > 15;
                  v = (a[7] == b[7]) && (r[7] != a[7]); end
         3'd2: begin s = ia - ib; r = s[7:0]; cf = ia < ib;
                  v = (a[7] != b[7]) && (r[7] != a[7]); end
         3'd3: begin s = (ia + 1) % 256; r = s[7:0]; v = (a == 8'h7F); end
         3'd4: begin s = (ia + 255) % 256; r = s[7:0]; v = (a == 8'h80); end
         3'd5: begin r = {a[6:0], c}; cf = a[7]; v = r[7] ^ cf; end
         3'd6: begin r = {c, a[7:1]}; cf = a[0]; v = r[7] ^ cf; end
         default: begin r = a; end
      endcase
      it.res   = r;
      it.hnzvc = {h, r[7], (r == 8'h00), v, cf};
      it.req   = req;
      return it;
   endfunction

   task automatic check(input string req, input string what, input logic [7:0] got,
                        input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
      end
   endtask

   // driver: apply one operation and queue its expected outcome
   task automatic issue(input logic [2:0] op, input logic [7:0] a, input logic [7:0] b,
                        input logic c, input string req);
      @(negedge clk);
      op_i = op; a_i = a; b_i = b; c_i = c;
      q.push_back(model(op, a, b, c, req));
   endtask

   // monitor: results appear one clock after the driver's negedge
   initial begin
      item_t it;
      forever begin
         @(posedge clk);
         #2;
         if (rst_n && q.size() > 0) begin
            it = q.pop_front();
            check(it.req, "result", res_o, it.res);
            check({it.req, "/R7"}, "flags hnzvc", {3'b000, h_o, n_o, z_o, v_o, c_o},
                  {3'b000, it.hnzvc});
            for (int k = 0; k < 8; k++) begin
               logic exp_br;
               cond_i = 3'(k);
               #0.25;
               case (k)
                  0: exp_br =  it.hnzvc[2];
                  1: exp_br = !it.hnzvc[2];
                  2: exp_br =  it.hnzvc[3];
                  3: exp_br = !it.hnzvc[3];
                  4: exp_br =  it.hnzvc[0];
                  5: exp_br = !it.hnzvc[0];
                  6: exp_br =  it.hnzvc[1];
                  default: exp_br = !it.hnzvc[1];
               endcase
               check("R9", $sformatf("branch cond %0d", k), {7'd0, br_o}, {7'd0, exp_br});
            end
         end
      end
   end

   // watchdog
   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not complete");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #2;
      // R8: reset values
      check("R8", "reset result", res_o, 8'h00);
      check("R8", "reset flags hnzvc", {3'b000, h_o, n_o, z_o, v_o, c_o}, 8'b0000_0100);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 add
      issue(3'd0, 8'h3D, 8'hE2, 1'b0, "R1");
      issue(3'd0, 8'hBD, 8'hA3, 1'b1, "R1");
      issue(3'd0, 8'h0F, 8'h01, 1'b0, "R1");
      issue(3'd0, 8'h80, 8'h80, 1'b0, "R1");
      issue(3'd0, 8'h40, 8'h40, 1'b0, "R1");
      // R2 add with carry
      issue(3'd1, 8'hFF, 8'h00, 1'b1, "R2");
      issue(3'd1, 8'h0E, 8'h01, 1'b1, "R2");
      issue(3'd1, 8'h7F, 8'h00, 1'b1, "R2");
      issue(3'd1, 8'h12, 8'h34, 1'b0, "R2");
      // R3 subtract
      issue(3'd2, 8'h05, 8'h03, 1'b1, "R3");
      issue(3'd2, 8'h03, 8'h05, 1'b0, "R3");
      issue(3'd2, 8'h80, 8'h01, 1'b0, "R3");
      issue(3'd2, 8'h7F, 8'hFF, 1'b0, "R3");
      issue(3'd2, 8'h42, 8'h42, 1'b1, "R3");
      // R4 increment / decrement, b ignored
      issue(3'd3, 8'h7F, 8'hAA, 1'b0, "R4");
      issue(3'd3, 8'hFF, 8'h55, 1'b1, "R4");
      issue(3'd3, 8'h10, 8'hFF, 1'b0, "R4");
      issue(3'd4, 8'h80, 8'h11, 1'b1, "R4");
      issue(3'd4, 8'h00, 8'h22, 1'b0, "R4");
      issue(3'd4, 8'h01, 8'h33, 1'b1, "R4");
      // R5 rotates through carry
      issue(3'd5, 8'h81, 8'h00, 1'b0, "R5");
      issue(3'd5, 8'h00, 8'h00, 1'b0, "R5");
      issue(3'd5, 8'h40, 8'h00, 1'b1, "R5");
      issue(3'd6, 8'h01, 8'h00, 1'b1, "R5");
      issue(3'd6, 8'h02, 8'h00, 1'b0, "R5");
      issue(3'd6, 8'hFE, 8'h00, 1'b1, "R5");
      // R6 pass
      issue(3'd7, 8'h00, 8'hFF, 1'b0, "R6");
      issue(3'd7, 8'hA5, 8'h5A, 1'b1, "R6");

      while (q.size() > 0) @(posedge clk);
      repeat (3) @(posedge clk);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule